// File: doc/BRIEF.md
# Dual-Clock FIFO with Half-Full and Almost-Empty Flags

This block is a first-in first-out buffer for 36-bit words. Its write port runs on one clock and its read port on another, unrelated clock. Its depth is a power of two chosen by a parameter, and the default is 16 words. It drives two active-low status outputs. The half-full flag marks that more than half the storage is in use. The almost-empty flag marks that only a few words are left, where "a few" is an offset that software picks.

A synchronous master reset, sampled on both clocks, sets up the block. While it is held, the block latches three settings from pins:
- the read style: standard, where every word needs a read strobe, or fall-through, where the oldest word waits on the output before it is requested;
- the update style of the almost-empty flag;
- the almost-empty offset.

In fall-through mode the output register counts as one extra storage place, so both flag thresholds move up by one word. The almost-empty flag has two update styles:
- Asynchronous style: a read edge pulls the flag low and a write edge pushes it high, with no synchronizer delay.
- Synchronous style: the flag is computed only in the read clock domain, from a synchronized copy of the write pointer.

Top module: `dcf_flag_fifo`

## Requirements
- R1: While master reset is high, both pointers are cleared and the data output is zero. After reset, the almost-empty flag reads low (0) and the half-full flag reads high (1).
- R2: In standard read mode (read-style pin 0 at reset), each rclk edge with the read enable high delivers the oldest stored word on the data output after that edge. Words come out in the order they were written.
- R3: In fall-through mode (read-style pin 1 at reset), the oldest word appears on the data output with no read strobe. A read edge removes it and shows the next word. The FIFO holds up to DEPTH+1 words.
- R4: A write while the storage is full is ignored. In standard mode at most DEPTH words are held; in fall-through mode at most DEPTH+1.
- R5: A standard-mode read while the FIFO is empty changes neither the data output nor the stored contents.
- R6: In standard mode the half-full flag is 0 when DEPTH/2+1 or more words are stored, and 1 otherwise.
- R7: In fall-through mode the half-full flag is 0 when DEPTH/2+2 or more words are stored, and 1 otherwise.
- R8: In standard mode, with latched offset n, the almost-empty flag is 0 when n or fewer words are stored, and 1 when n+1 or more are stored.
- R9: In fall-through mode the almost-empty flag is 0 when n+1 or fewer words are stored, and 1 when n+2 or more are stored.
- R10: With the flag-style pin 0 at reset (asynchronous style), both flags follow the stored count without delay. They change right after the wclk edge of an accepted write or the rclk edge of an accepted read.
- R11: With the flag-style pin 1 at reset (synchronous style), the almost-empty flag is updated only by rclk. It uses a write pointer carried through a two-stage Gray-code synchronizer, so it does not change at the write edge itself but settles a few rclk cycles later.
- R12: Read style, flag style and offset are taken only while master reset is high. Changing those pins afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, synchronous to both clocks |
| fwft_sel | input | 1 | Read style latched at reset: 0 standard, 1 fall-through |
| pae_sync_sel | input | 1 | Almost-empty style latched at reset: 0 asynchronous, 1 synchronous |
| pae_offset | input | ADDR_W | Almost-empty offset n, latched at reset |
| wen | input | 1 | Write enable, sampled on wclk |
| din | input | DATA_W | Write data |
| ren | input | 1 | Read enable, sampled on rclk |
| dout | output | DATA_W | Read data, registered on rclk |
| hf_n | output | 1 | Half-full flag, active low |
| pae_n | output | 1 | Almost-empty flag, active low |

## Verification
The checker watches, on every cycle, that the stored count never goes beyond the capacity of the active mode. It also checks that a write against full storage leaves the write pointer unchanged, and that a standard read on empty storage freezes the output and the consume pointer. Two more cycle-by-cycle checks: the fall-through output never runs more than one word ahead of consumption, and the latched settings stay put between resets. Only the directed scenarios can show the rest: where each flag threshold sits in each mode, that the asynchronous flag moves on the very edge that changed the count while the synchronous one lags, and that data comes out in write order.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  localparam int unsigned DATA_W = 36;

  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;

  typedef enum logic {
    PAE_ASYNC = 1'b0,
    PAE_SYNC  = 1'b1
  } pae_mode_e;

  typedef struct packed {
    rd_mode_e  rd_mode;
    pae_mode_e pae_mode;
  } mode_t;

endpackage

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // write port, no reset on the array so it maps onto block RAM
  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port with synchronous output reset
  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             src_clk,
  input  logic             src_rst,
  input  logic [WIDTH-1:0] src_bin,
  input  logic             dst_clk,
  input  logic             dst_rst,
  output logic [WIDTH-1:0] dst_bin
);
  logic [WIDTH-1:0] src_gray;
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  // gray code registered in the source domain: one bit moves per step
  always_ff @(posedge src_clk) begin
    if (src_rst) src_gray <= '0;
    else         src_gray <= src_bin ^ (src_bin >> 1);
  end

  // two flops in the destination domain
  always_ff @(posedge dst_clk) begin
    if (dst_rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= src_gray;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    for (int i = 0; i < int'(WIDTH); i++) begin
      dst_bin[i] = ^(sync_q >> i);
    end
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wen,
  input  logic [PTR_W-1:0]  fptr_sync,
  output logic [PTR_W-1:0]  wptr,
  output logic              we,
  output logic [ADDR_W-1:0] waddr
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [PTR_W-1:0] ram_used;
  logic             ram_full;

  // conservative: the fetch pointer seen here can only lag
  assign ram_used = wptr - fptr_sync;
  assign ram_full = (ram_used == PTR_W'(DEPTH));
  assign we       = wen && !ram_full;
  assign waddr    = wptr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)     wptr <= '0;
    else if (we) wptr <= wptr + 1'b1;
  end
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fwft_sel,
  input  logic              pae_sync_sel,
  input  logic [ADDR_W-1:0] offset_in,
  input  logic              ren,
  input  logic [PTR_W-1:0]  wptr_sync,
  output mode_t             mode_q,
  output logic [ADDR_W-1:0] offset_q,
  output logic [PTR_W-1:0]  fptr,
  output logic [PTR_W-1:0]  cptr,
  output logic              fetch,
  output logic [ADDR_W-1:0] raddr
);
  logic ram_avail;
  logic out_valid;
  logic consume;

  assign ram_avail = (wptr_sync != fptr);
  assign out_valid = (fptr != cptr);
  assign raddr     = fptr[ADDR_W-1:0];

  always_comb begin
    case (mode_q.rd_mode)
      RD_FWFT: begin
        consume = ren && out_valid;
        fetch   = ram_avail && (!out_valid || consume);
      end
      default: begin
        consume = ren && ram_avail;
        fetch   = consume;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q.rd_mode  <= fwft_sel ? RD_FWFT : RD_STD;
      mode_q.pae_mode <= pae_sync_sel ? PAE_SYNC : PAE_ASYNC;
      offset_q        <= offset_in;
      fptr            <= '0;
      cptr            <= '0;
    end else begin
      if (fetch)   fptr <= fptr + 1'b1;
      if (consume) cptr <= cptr + 1'b1;
    end
  end
endmodule

// File: rtl/dcf_flags.sv
module dcf_flags
  import dcf_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PTR_W  = 6
) (
  input  logic              rclk,
  input  logic              rst,
  input  mode_t             mode_q,
  input  logic [ADDR_W-1:0] offset_q,
  input  logic [PTR_W-1:0]  wptr,
  input  logic [PTR_W-1:0]  wptr_sync,
  input  logic [PTR_W-1:0]  cptr,
  output logic              hf_n,
  output logic              pae_n
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned HALF  = DEPTH / 2;

  logic [PTR_W-1:0] extra;
  logic [PTR_W-1:0] hf_thr;
  logic [PTR_W-1:0] pae_thr;
  logic [PTR_W-1:0] occ_live;
  logic [PTR_W-1:0] occ_sync;
  logic             pae_live_n;
  logic             pae_reg_n;

  // the fall-through output register adds one storage place
  assign extra    = (mode_q.rd_mode == RD_FWFT) ? PTR_W'(1) : PTR_W'(0);
  assign hf_thr   = PTR_W'(HALF + 1) + extra;
  assign pae_thr  = PTR_W'(offset_q) + extra;

  // live count: each pointer moves only on its own clock edge
  assign occ_live = wptr - cptr;
  assign occ_sync = wptr_sync - cptr;

  assign hf_n       = !(occ_live >= hf_thr);
  assign pae_live_n = !(occ_live <= pae_thr);

  always_ff @(posedge rclk) begin
    if (rst) pae_reg_n <= 1'b0;
    else     pae_reg_n <= !(occ_sync <= pae_thr);
  end

  assign pae_n = (mode_q.pae_mode == PAE_SYNC) ? pae_reg_n : pae_live_n;
endmodule

// File: rtl/dcf_flag_fifo.sv
module dcf_flag_fifo
  import dcf_pkg::*;
#(
  parameter int unsigned DATA_W = dcf_pkg::DATA_W,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst,
  input  logic              fwft_sel,
  input  logic              pae_sync_sel,
  input  logic [ADDR_W-1:0] pae_offset,
  input  logic              wen,
  input  logic [DATA_W-1:0] din,
  input  logic              ren,
  output logic [DATA_W-1:0] dout,
  output logic              hf_n,
  output logic              pae_n
);
  // two spare bits: count range 0..DEPTH+1 stays unambiguous
  localparam int unsigned PTR_W = ADDR_W + 2;

  logic [PTR_W-1:0]  wptr;
  logic [PTR_W-1:0]  fptr;
  logic [PTR_W-1:0]  cptr;
  logic [PTR_W-1:0]  wptr_sync;
  logic [PTR_W-1:0]  fptr_sync;
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic              fetch;
  logic [ADDR_W-1:0] raddr;
  mode_t             mode_q;
  logic [ADDR_W-1:0] offset_q;

  dcf_wr_ctl #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_wr (
    .clk(wclk), .rst(mrst), .wen(wen), .fptr_sync(fptr_sync),
    .wptr(wptr), .we(we), .waddr(waddr)
  );

  dcf_rd_ctl #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_rd (
    .clk(rclk), .rst(mrst), .fwft_sel(fwft_sel), .pae_sync_sel(pae_sync_sel),
    .offset_in(pae_offset), .ren(ren), .wptr_sync(wptr_sync),
    .mode_q(mode_q), .offset_q(offset_q), .fptr(fptr), .cptr(cptr),
    .fetch(fetch), .raddr(raddr)
  );

  dcf_gray_sync #(.WIDTH(PTR_W)) u_w2r (
    .src_clk(wclk), .src_rst(mrst), .src_bin(wptr),
    .dst_clk(rclk), .dst_rst(mrst), .dst_bin(wptr_sync)
  );

  dcf_gray_sync #(.WIDTH(PTR_W)) u_r2w (
    .src_clk(rclk), .src_rst(mrst), .src_bin(fptr),
    .dst_clk(wclk), .dst_rst(mrst), .dst_bin(fptr_sync)
  );

  dcf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
    .rclk(rclk), .rrst(mrst), .re(fetch), .raddr(raddr), .rdata(dout)
  );

  dcf_flags #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_flags (
    .rclk(rclk), .rst(mrst), .mode_q(mode_q), .offset_q(offset_q),
    .wptr(wptr), .wptr_sync(wptr_sync), .cptr(cptr),
    .hf_n(hf_n), .pae_n(pae_n)
  );
endmodule

// File: rtl/dcf_flag_fifo_chk.sv
module dcf_flag_fifo_chk
  import dcf_pkg::*;
#(
  parameter int unsigned DATA_W = dcf_pkg::DATA_W,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PTR_W  = ADDR_W + 2
) (
  input logic              wclk,
  input logic              rclk,
  input logic              mrst,
  input logic              wen,
  input logic              ren,
  input logic [PTR_W-1:0]  wptr,
  input logic [PTR_W-1:0]  fptr,
  input logic [PTR_W-1:0]  cptr,
  input logic [PTR_W-1:0]  wptr_sync,
  input logic [PTR_W-1:0]  fptr_sync,
  input mode_t             mode_q,
  input logic [ADDR_W-1:0] offset_q,
  input logic [DATA_W-1:0] dout
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [PTR_W-1:0] cap;
  assign cap = (mode_q.rd_mode == RD_FWFT) ? PTR_W'(DEPTH + 1) : PTR_W'(DEPTH);

  // R4: the stored count never exceeds the capacity of the mode
  assert_no_overfill_R4: assert property (@(posedge rclk) disable iff (mrst)
    (PTR_W'(wptr - cptr) <= cap));

  // R4: a write against full storage leaves the write pointer alone
  assert_full_write_ignored_R4: assert property (@(posedge wclk) disable iff (mrst)
    (wen && (PTR_W'(wptr - fptr_sync) == PTR_W'(DEPTH))) |=> (wptr == $past(wptr)));

  // R5: a standard read on empty storage freezes output and consume pointer
  assert_empty_read_ignored_R5: assert property (@(posedge rclk) disable iff (mrst)
    (ren && (mode_q.rd_mode == RD_STD) && (wptr_sync == fptr))
      |=> ($stable(dout) && $stable(cptr)));

  // R3: the fall-through output runs at most one word ahead
  assert_fwft_one_ahead_R3: assert property (@(posedge rclk) disable iff (mrst)
    (PTR_W'(fptr - cptr) <= PTR_W'(1)));

  // R12: settings latched at reset stay fixed afterwards
  assert_config_held_R12: assert property (@(posedge rclk) disable iff (mrst)
    !$past(mrst) |-> ($stable(mode_q) && $stable(offset_q)));
endmodule

bind dcf_flag_fifo dcf_flag_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst(mrst), .wen(wen), .ren(ren),
  .wptr(wptr), .fptr(fptr), .cptr(cptr), .wptr_sync(wptr_sync),
  .fptr_sync(fptr_sync), .mode_q(mode_q), .offset_q(offset_q), .dout(dout)
);

// File: tb/test_dcf_flag_fifo.sv
module test_dcf_flag_fifo;
  localparam int DW    = 36;
  localparam int AW    = 4;
  localparam int DEPTH = 16;

  logic          wclk = 1'b0;
  logic          rclk = 1'b0;
  logic          mrst = 1'b1;
  logic          fwft_sel = 1'b0;
  logic          pae_sync_sel = 1'b0;
  logic [AW-1:0] pae_offset = '0;
  logic          wen = 1'b0;
  logic [DW-1:0] din = '0;
  logic          ren = 1'b0;
  logic [DW-1:0] dout;
  logic          hf_n;
  logic          pae_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 wclk = ~wclk;   // 100 MHz write clock
  always #7 rclk = ~rclk;   // unrelated read clock

  dcf_flag_fifo #(.DATA_W(DW), .ADDR_W(AW)) i_dcf_flag_fifo (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .fwft_sel(fwft_sel),
    .pae_sync_sel(pae_sync_sel), .pae_offset(pae_offset), .wen(wen), .din(din),
    .ren(ren), .dout(dout), .hf_n(hf_n), .pae_n(pae_n)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  task automatic do_reset(input logic fwft, input logic sync, input logic [AW-1:0] n);
    @(negedge wclk);
    mrst = 1'b1; fwft_sel = fwft; pae_sync_sel = sync; pae_offset = n;
    wen = 1'b0; ren = 1'b0;
    repeat (4) @(negedge rclk);
    @(negedge wclk);
    mrst = 1'b0;
    repeat (2) @(negedge rclk);
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wclk); wen = 1'b1; din = d;
    @(negedge wclk); wen = 1'b0;
  endtask

  task automatic pop();
    @(negedge rclk); ren = 1'b1;
    @(negedge rclk); ren = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
  endtask

  // R1: state right after master reset
  task automatic test_reset();
    do_reset(1'b0, 1'b0, 4'd3);
    check("R1 pae_n after reset", DW'(pae_n), DW'(0));
    check("R1 hf_n after reset", DW'(hf_n), DW'(1));
    check("R1 dout after reset", dout, '0);
  endtask

  // standard mode, asynchronous flag, offset 3
  task automatic test_std_fill();
    for (int k = 1; k <= DEPTH; k++) begin
      push(DW'(k));
      check("R8 R10 pae_n on write", DW'(pae_n), DW'(k <= 3 ? 0 : 1));
      check("R6 R10 hf_n on write", DW'(hf_n), DW'(k >= DEPTH/2 + 1 ? 0 : 1));
    end
    push(DW'(17));  // R4: storage full, must be dropped
    push(DW'(18));
    settle();
    check("R4 hf_n when full", DW'(hf_n), DW'(0));
    for (int k = 1; k <= DEPTH; k++) begin
      pop();
      check("R2 read order", dout, DW'(k));
      check("R6 R10 hf_n on read", DW'(hf_n), DW'((DEPTH - k) >= DEPTH/2 + 1 ? 0 : 1));
      check("R8 R10 pae_n on read", DW'(pae_n), DW'((DEPTH - k) <= 3 ? 0 : 1));
    end
    settle();
    pop();
    check("R5 R4 empty read keeps dout", dout, DW'(DEPTH));
    check("R5 pae_n when empty", DW'(pae_n), DW'(0));
  endtask

  // fall-through mode, asynchronous flag, offset 2
  task automatic test_fwft();
    do_reset(1'b1, 1'b0, 4'd2);
    push(DW'(100));
    check("R9 pae_n count 1", DW'(pae_n), DW'(0));
    settle();
    check("R3 first word falls through", dout, DW'(100));
    for (int k = 2; k <= DEPTH + 4; k++) begin
      int cnt;
      push(DW'(99 + k));
      cnt = (k > DEPTH + 1) ? DEPTH + 1 : k;
      check("R9 pae_n fwft", DW'(pae_n), DW'(cnt <= 3 ? 0 : 1));
      check("R7 hf_n fwft", DW'(hf_n), DW'(cnt >= DEPTH/2 + 2 ? 0 : 1));
    end
    settle();
    for (int i = 0; i <= DEPTH; i++) begin
      check("R3 R4 fwft order and depth+1", dout, DW'(100 + i));
      pop();
      check("R7 hf_n fwft drain", DW'(hf_n), DW'((DEPTH - i) >= DEPTH/2 + 2 ? 0 : 1));
    end
    check("R9 pae_n fwft drained", DW'(pae_n), DW'(0));
  endtask

  // standard mode, synchronous flag, offset 1
  task automatic test_sync_pae();
    do_reset(1'b0, 1'b1, 4'd1);
    push(DW'(7));
    settle();
    check("R11 pae_n count 1", DW'(pae_n), DW'(0));
    push(DW'(8));
    check("R11 pae_n not at write edge", DW'(pae_n), DW'(0));
    settle();
    check("R11 pae_n after sync", DW'(pae_n), DW'(1));
    pop();
    settle();
    check("R11 pae_n after read", DW'(pae_n), DW'(0));
    check("R2 sync mode data", dout, DW'(7));
  endtask

  // pins changed after reset must not matter
  task automatic test_latch();
    do_reset(1'b0, 1'b0, 4'd3);
    fwft_sel = 1'b1; pae_offset = 4'd7; pae_sync_sel = 1'b1;
    for (int k = 1; k <= 4; k++) push(DW'(40 + k));
    settle();
    check("R12 offset kept at 3", DW'(pae_n), DW'(1));
    check("R12 no fall-through", dout, '0);
    pop();
    check("R12 standard read", dout, DW'(41));
  endtask

  initial begin
    test_reset();
    test_std_fill();
    test_fwft();
    test_sync_pae();
    test_latch();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge wclk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule